// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the raster timing for a single display. A column counter and a row counter run over the programmed totals. From them the block derives horizontal and vertical sync pulses, a data-enable window and two single-cycle fetch strobes, one for each input plane. These strobes tell upstream fetch logic when to begin work on the next frame. For every active pixel the block also reports which source is shown: the constant background color, the primary plane or the secondary plane. The choice follows a display mode, and a separate panic mode takes over while the panic input is high.

Software programs the block through a 32-bit word interface. Writes are synchronous and reads are combinational. When shadowing is on, configuration writes land in a shadow bank. Writing the load token commits the whole bank at the next frame boundary, so a frame never mixes old and new settings. Software can read a timestamp that packs the frame and line indices. Two sticky flags report on the secondary input.

Top module: `raster_timing_gen`

Word addresses: 0 control (bit 0 shadow enable), 1 horizontal size, 2 horizontal sync, 3 vertical size, 4 vertical sync, 5 primary strobe, 6 secondary strobe, 7 primary start, 8 secondary start, 9 display mode, 10 panic mode, 11 background color, 12 run (bit 0), 13 load token (bit 0), 14 timestamp, 15 channel status, 16 status clear.

## Requirements
- R1: While run is 1, the column counts from 0 up to the horizontal total-minus-one field (bits 29:16 of word 1) and then wraps to 0. The row advances on each wrap, up to the vertical total-minus-one field (bits 29:16 of word 3), and then wraps. While run is 0, both counters return to 0 on the next edge. col_out and row_out show the current position.
- R2: de_out is 1 exactly when run is 1, the column is below the horizontal active count (bits 13:0 of word 1) and the row is below the vertical active count (bits 13:0 of word 3).
- R3: In words 2 and 4, bits 29:16 hold sync-plus-back-porch minus one (B), bits 13:0 hold sync width minus one (W), and bit 31 enables the pulse. With total T (the stored field plus one), the sync output is high for counts from T-(B+1) through T-(B+1)+W. hsync_out uses the column and vsync_out uses the row.
- R4: Word 5 (primary) and word 6 (secondary) each hold an enable in bit 31, a row in bits 29:16 and a column in bits 13:0. The matching strobe output is high for the single position where both counters equal that row and column. It stays low when bit 31 is 0.
- R5: src_out encodes 0 blank (outside the active window), 1 background, 2 primary, 3 secondary. Words 7 and 8 hold start X plus one in bits 13:0 and start Y plus one in bits 29:16. A plane covers a pixel when both coordinates are at or past its start. Mode 5 (bits 2:0 of word 9) shows the secondary on top of the primary, and shows the background where neither plane covers the pixel. Every other mode value shows the background. color_out carries word 11 (bits 29:0) when the source is background and is 0 otherwise.
- R6: While panic_in is 1, the mode in word 10 replaces the mode in word 9, starting in the same cycle.
- R7: With control bit 0 set, writes to words 1 to 11 change only the read-back value. Writing 1 to bit 0 of word 13 makes the written values take effect from the first pixel (column 0, row 0) of the next frame. Word 13 bit 0 reads 1 until the load is done. With control bit 0 clear, writes take effect on the next edge.
- R8: While run is 0, a pending load completes on the next edge.
- R9: Word 14 reads the frame index in bits 31:14 and the row in bits 13:0. The frame index increments by one on each frame wrap and is 0 after reset.
- R10: In word 15, bit 16 becomes 1 after sec_empty_in is high on a pixel whose source is secondary, and bit 24 becomes 1 when sec_sync_in is high at a frame wrap. sec_empty_in has no effect on any other pixel. Both bits stay set until a write to word 16 with bit 16 set, which clears them.
- R11: After reset all words read 0, the counters are at 0 and every timing output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the word interface |
| cfg_addr | input | 5 | Word address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| panic_in | input | 1 | Selects the panic display mode while high |
| sec_empty_in | input | 1 | Secondary input reports no data |
| sec_sync_in | input | 1 | Secondary input reports it is in step |
| de_out | output | 1 | Data-enable window |
| hsync_out | output | 1 | Horizontal sync |
| vsync_out | output | 1 | Vertical sync |
| kick_pri_out | output | 1 | Primary fetch strobe |
| kick_sec_out | output | 1 | Secondary fetch strobe |
| src_out | output | 2 | Content source of the current pixel |
| color_out | output | 30 | Background color when the source is background |
| col_out | output | 14 | Current column |
| row_out | output | 14 | Current row |

## Verification
The bench runs a small 10 by 6 raster and checks the edges of the data-enable window, the two-column and one-row sync pulses, both strobes and the source seen where the two planes overlap. A generator that treats the stored totals, sync widths or start positions as literal values shifts each of these by one position.

The bench writes a mode change under shadowing and then checks that the old mode still holds in the current frame and the new mode appears exactly at column 0, row 0 of the next frame. A design that commits early, late or only partly fails these checks.

Further checks cover a load while stopped, panic override, an empty report on a primary pixel that must be ignored, and the sticky flags with their clear. These catch a design that waits for a frame that never comes, sets the empty flag on any pixel, or loses a flag before it is cleared.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int REG_W   = 32;
  localparam int FLD_W   = 14;
  localparam int ADDR_W  = 5;
  localparam int COLOR_W = 30;
  localparam int MODE_W  = 3;
  localparam int NPLANE  = 2;
  localparam int FIDX_W  = REG_W - FLD_W;

  localparam logic [ADDR_W-1:0] A_CTRL  = 5'd0;
  localparam logic [ADDR_W-1:0] A_HSIZE = 5'd1;
  localparam logic [ADDR_W-1:0] A_HSYN  = 5'd2;
  localparam logic [ADDR_W-1:0] A_VSIZE = 5'd3;
  localparam logic [ADDR_W-1:0] A_VSYN  = 5'd4;
  localparam logic [ADDR_W-1:0] A_KICKP = 5'd5;
  localparam logic [ADDR_W-1:0] A_KICKS = 5'd6;
  localparam logic [ADDR_W-1:0] A_POSP  = 5'd7;
  localparam logic [ADDR_W-1:0] A_POSS  = 5'd8;
  localparam logic [ADDR_W-1:0] A_MODE  = 5'd9;
  localparam logic [ADDR_W-1:0] A_PMODE = 5'd10;
  localparam logic [ADDR_W-1:0] A_BG    = 5'd11;
  localparam logic [ADDR_W-1:0] A_RUN   = 5'd12;
  localparam logic [ADDR_W-1:0] A_TOKEN = 5'd13;
  localparam logic [ADDR_W-1:0] A_STAMP = 5'd14;
  localparam logic [ADDR_W-1:0] A_CHST  = 5'd15;
  localparam logic [ADDR_W-1:0] A_CHCLR = 5'd16;

  localparam logic [MODE_W-1:0] MODE_OVERLAY = 3'd5;

  localparam int ST_FIFO_BIT = 16;
  localparam int ST_SYNC_BIT = 24;

  typedef enum logic [1:0] {
    SRC_BLANK = 2'd0,
    SRC_BG    = 2'd1,
    SRC_PRI   = 2'd2,
    SRC_SEC   = 2'd3
  } src_e;

  typedef struct packed {
    logic [FLD_W-1:0] tot_f;
    logic [FLD_W-1:0] act;
    logic [FLD_W-1:0] sbp_f;
    logic [FLD_W-1:0] sw_f;
    logic             sync_en;
  } axis_t;

  typedef struct packed {
    logic             en;
    logic [FLD_W-1:0] row;
    logic [FLD_W-1:0] col;
  } kick_t;

  typedef struct packed {
    logic [FLD_W-1:0] y1;
    logic [FLD_W-1:0] x1;
  } pos_t;

  typedef struct packed {
    axis_t                    h;
    axis_t                    v;
    kick_t [NPLANE-1:0]       kick;
    pos_t  [NPLANE-1:0]       pos;
    logic  [MODE_W-1:0]       mode;
    logic  [MODE_W-1:0]       pmode;
    logic  [COLOR_W-1:0]      bg;
  } cfg_t;

  function automatic logic is_cfg_addr(logic [ADDR_W-1:0] a);
    return (a >= A_HSIZE) && (a <= A_BG);
  endfunction

  // Sync window: start = total - (sbp) = tot_f - sbp_f ; length = sw_f + 1
  function automatic logic in_sync(logic [FLD_W-1:0] cnt, logic [FLD_W-1:0] tot_f,
                                   logic [FLD_W-1:0] sbp_f, logic [FLD_W-1:0] sw_f);
    logic [FLD_W:0] first;
    logic [FLD_W:0] past_end;
    first    = {1'b0, tot_f} - {1'b0, sbp_f};
    past_end = first + {1'b0, sw_f} + 1'b1;
    return ({1'b0, cnt} >= first) && ({1'b0, cnt} < past_end);
  endfunction

  // Start registers hold start+1, so compare coordinate+1 against them
  function automatic logic in_plane(logic [FLD_W-1:0] col, logic [FLD_W-1:0] row,
                                    pos_t p);
    return (({1'b0, col} + 1'b1) >= {1'b0, p.x1}) &&
           (({1'b0, row} + 1'b1) >= {1'b0, p.y1});
  endfunction

  function automatic cfg_t cfg_write(cfg_t c, logic [ADDR_W-1:0] a, logic [REG_W-1:0] d);
    cfg_t r;
    r = c;
    case (a)
      A_HSIZE: begin r.h.tot_f = d[16 +: FLD_W]; r.h.act = d[0 +: FLD_W]; end
      A_HSYN:  begin r.h.sync_en = d[31]; r.h.sbp_f = d[16 +: FLD_W]; r.h.sw_f = d[0 +: FLD_W]; end
      A_VSIZE: begin r.v.tot_f = d[16 +: FLD_W]; r.v.act = d[0 +: FLD_W]; end
      A_VSYN:  begin r.v.sync_en = d[31]; r.v.sbp_f = d[16 +: FLD_W]; r.v.sw_f = d[0 +: FLD_W]; end
      A_KICKP: begin r.kick[0].en = d[31]; r.kick[0].row = d[16 +: FLD_W]; r.kick[0].col = d[0 +: FLD_W]; end
      A_KICKS: begin r.kick[1].en = d[31]; r.kick[1].row = d[16 +: FLD_W]; r.kick[1].col = d[0 +: FLD_W]; end
      A_POSP:  begin r.pos[0].y1 = d[16 +: FLD_W]; r.pos[0].x1 = d[0 +: FLD_W]; end
      A_POSS:  begin r.pos[1].y1 = d[16 +: FLD_W]; r.pos[1].x1 = d[0 +: FLD_W]; end
      A_MODE:  r.mode  = d[MODE_W-1:0];
      A_PMODE: r.pmode = d[MODE_W-1:0];
      A_BG:    r.bg    = d[COLOR_W-1:0];
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [REG_W-1:0] cfg_word(cfg_t c, logic [ADDR_W-1:0] a);
    case (a)
      A_HSIZE: return {2'b0, c.h.tot_f, 2'b0, c.h.act};
      A_HSYN:  return {c.h.sync_en, 1'b0, c.h.sbp_f, 2'b0, c.h.sw_f};
      A_VSIZE: return {2'b0, c.v.tot_f, 2'b0, c.v.act};
      A_VSYN:  return {c.v.sync_en, 1'b0, c.v.sbp_f, 2'b0, c.v.sw_f};
      A_KICKP: return {c.kick[0].en, 1'b0, c.kick[0].row, 2'b0, c.kick[0].col};
      A_KICKS: return {c.kick[1].en, 1'b0, c.kick[1].row, 2'b0, c.kick[1].col};
      A_POSP:  return {2'b0, c.pos[0].y1, 2'b0, c.pos[0].x1};
      A_POSS:  return {2'b0, c.pos[1].y1, 2'b0, c.pos[1].x1};
      A_MODE:  return {{(REG_W-MODE_W){1'b0}}, c.mode};
      A_PMODE: return {{(REG_W-MODE_W){1'b0}}, c.pmode};
      A_BG:    return {{(REG_W-COLOR_W){1'b0}}, c.bg};
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import raster_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              frame_wrap,
  input  logic [REG_W-1:0]  stamp,
  input  logic [REG_W-1:0]  chstat,
  output logic              run,
  output logic              stat_clr,
  output logic              commit,
  output cfg_t              act
);

  cfg_t shd;
  logic shd_on;
  logic tok;
  logic cfg_wr;
  logic tok_wr;
  logic unused_wbits;

  assign unused_wbits = cfg_wdata[30];
  assign cfg_wr   = cfg_we && is_cfg_addr(cfg_addr);
  assign tok_wr   = cfg_we && (cfg_addr == A_TOKEN) && cfg_wdata[0];
  assign stat_clr = cfg_we && (cfg_addr == A_CHCLR) && cfg_wdata[ST_FIFO_BIT];
  assign commit   = tok && (!run || frame_wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd    <= '0;
      act    <= '0;
      shd_on <= 1'b0;
      run    <= 1'b0;
      tok    <= 1'b0;
    end else begin
      if (cfg_we && cfg_addr == A_CTRL) shd_on <= cfg_wdata[0];
      if (cfg_we && cfg_addr == A_RUN)  run    <= cfg_wdata[0];
      if (cfg_wr) shd <= cfg_write(shd, cfg_addr, cfg_wdata);
      if (cfg_wr && !shd_on)
        act <= cfg_write(commit ? shd : act, cfg_addr, cfg_wdata);
      else if (commit)
        act <= shd;
      if (tok_wr)      tok <= 1'b1;
      else if (commit) tok <= 1'b0;
    end
  end

  always_comb begin
    if (is_cfg_addr(cfg_addr)) cfg_rdata = cfg_word(shd, cfg_addr);
    else begin
      case (cfg_addr)
        A_CTRL:  cfg_rdata = {{(REG_W-1){1'b0}}, shd_on};
        A_RUN:   cfg_rdata = {{(REG_W-1){1'b0}}, run};
        A_TOKEN: cfg_rdata = {{(REG_W-1){1'b0}}, tok};
        A_STAMP: cfg_rdata = stamp;
        A_CHST:  cfg_rdata = chstat;
        default: cfg_rdata = '0;
      endcase
    end
  end

  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shd_on && run && !frame_wrap) |=> $stable(act));

  // R8
  idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok && !run && !tok_wr) |=> !tok);

endmodule

// File: rtl/rtg_counter.sv
module rtg_counter
  import raster_pkg::*;
#(
  parameter int IDX_W = FIDX_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [FLD_W-1:0] htot_f,
  input  logic [FLD_W-1:0] vtot_f,
  output logic [FLD_W-1:0] col,
  output logic [FLD_W-1:0] row,
  output logic             frame_wrap,
  output logic [IDX_W-1:0] fidx
);

  logic line_end;
  logic last_row;

  assign line_end   = (col >= htot_f);
  assign last_row   = (row >= vtot_f);
  assign frame_wrap = run && line_end && last_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col  <= '0;
      row  <= '0;
      fidx <= '0;
    end else if (!run) begin
      col <= '0;
      row <= '0;
    end else if (line_end) begin
      col <= '0;
      row <= last_row ? '0 : row + 1'b1;
      if (last_row) fidx <= fidx + 1'b1;
    end else begin
      col <= col + 1'b1;
    end
  end

  // R1
  idle_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (col == '0 && row == '0));

  // R9
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (fidx == $past(fidx) + 1'b1));

endmodule

// File: rtl/rtg_pixel.sv
module rtg_pixel
  import raster_pkg::*;
(
  input  logic               run,
  input  logic [FLD_W-1:0]   col,
  input  logic [FLD_W-1:0]   row,
  input  cfg_t               cfg,
  input  logic               panic,
  output logic               de,
  output logic               hsync,
  output logic               vsync,
  output logic [NPLANE-1:0]  kick,
  output src_e               src,
  output logic [COLOR_W-1:0] color
);

  logic [NPLANE-1:0] hit;
  logic [MODE_W-1:0] mode_eff;

  for (genvar p = 0; p < NPLANE; p++) begin : g_plane
    assign kick[p] = run && cfg.kick[p].en &&
                     (col == cfg.kick[p].col) && (row == cfg.kick[p].row);
    assign hit[p]  = in_plane(col, row, cfg.pos[p]);
  end

  assign de    = run && (col < cfg.h.act) && (row < cfg.v.act);
  assign hsync = run && cfg.h.sync_en && in_sync(col, cfg.h.tot_f, cfg.h.sbp_f, cfg.h.sw_f);
  assign vsync = run && cfg.v.sync_en && in_sync(row, cfg.v.tot_f, cfg.v.sbp_f, cfg.v.sw_f);
  assign mode_eff = panic ? cfg.pmode : cfg.mode;

  always_comb begin
    if (!de)                          src = SRC_BLANK;
    else if (mode_eff != MODE_OVERLAY) src = SRC_BG;
    else if (hit[1])                  src = SRC_SEC;
    else if (hit[0])                  src = SRC_PRI;
    else                              src = SRC_BG;
  end

  assign color = (src == SRC_BG) ? cfg.bg : '0;

endmodule

// File: rtl/rtg_status.sv
module rtg_status
  import raster_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  src_e             src,
  input  logic             sec_empty_in,
  input  logic             sec_sync_in,
  input  logic             frame_wrap,
  input  logic             clr,
  output logic [REG_W-1:0] chstat
);

  logic fifo_flag;
  logic sync_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_flag <= 1'b0;
      sync_flag <= 1'b0;
    end else if (clr) begin
      fifo_flag <= 1'b0;
      sync_flag <= 1'b0;
    end else begin
      if (sec_empty_in && src == SRC_SEC) fifo_flag <= 1'b1;
      if (sec_sync_in && frame_wrap)      sync_flag <= 1'b1;
    end
  end

  always_comb begin
    chstat = '0;
    chstat[ST_FIFO_BIT] = fifo_flag;
    chstat[ST_SYNC_BIT] = sync_flag;
  end

  // R10
  fifo_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_flag) |-> $past(sec_empty_in && src == SRC_SEC));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  input  logic               panic_in,
  input  logic               sec_empty_in,
  input  logic               sec_sync_in,
  output logic               de_out,
  output logic               hsync_out,
  output logic               vsync_out,
  output logic               kick_pri_out,
  output logic               kick_sec_out,
  output logic [1:0]         src_out,
  output logic [COLOR_W-1:0] color_out,
  output logic [FLD_W-1:0]   col_out,
  output logic [FLD_W-1:0]   row_out
);

  cfg_t              act;
  logic              run;
  logic              stat_clr;
  logic              commit;
  logic              frame_wrap;
  logic [FIDX_W-1:0] fidx;
  logic [REG_W-1:0]  stamp;
  logic [REG_W-1:0]  chstat;
  logic [NPLANE-1:0] kick;
  src_e              src;
  logic              unused_commit;

  assign unused_commit = commit;
  assign stamp = {fidx, row_out};

  rtg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frame_wrap(frame_wrap),
    .stamp(stamp), .chstat(chstat), .run(run), .stat_clr(stat_clr),
    .commit(commit), .act(act)
  );

  rtg_counter #(.IDX_W(FIDX_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .htot_f(act.h.tot_f),
    .vtot_f(act.v.tot_f), .col(col_out), .row(row_out),
    .frame_wrap(frame_wrap), .fidx(fidx)
  );

  rtg_pixel u_pix (
    .run(run), .col(col_out), .row(row_out), .cfg(act), .panic(panic_in),
    .de(de_out), .hsync(hsync_out), .vsync(vsync_out), .kick(kick),
    .src(src), .color(color_out)
  );

  rtg_status u_stat (
    .clk(clk), .rst_n(rst_n), .src(src), .sec_empty_in(sec_empty_in),
    .sec_sync_in(sec_sync_in), .frame_wrap(frame_wrap), .clr(stat_clr),
    .chstat(chstat)
  );

  assign kick_pri_out = kick[0];
  assign kick_sec_out = kick[1];
  assign src_out      = src;

endmodule

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        panic_in = 1'b0;
  logic        sec_empty_in = 1'b0;
  logic        sec_sync_in = 1'b0;
  logic        de_out, hsync_out, vsync_out, kick_pri_out, kick_sec_out;
  logic [1:0]  src_out;
  logic [29:0] color_out;
  logic [13:0] col_out, row_out;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  raster_timing_gen u_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .panic_in(panic_in),
    .sec_empty_in(sec_empty_in), .sec_sync_in(sec_sync_in),
    .de_out(de_out), .hsync_out(hsync_out), .vsync_out(vsync_out),
    .kick_pri_out(kick_pri_out), .kick_sec_out(kick_sec_out),
    .src_out(src_out), .color_out(color_out), .col_out(col_out), .row_out(row_out)
  );

  localparam int HTOT = 10;
  localparam logic [31:0] BG = 32'h000F_FC00;

  // {position index v*HTOT+h, expected {de,hsync,vsync,kick_pri,kick_sec,src[1:0]}}
  localparam logic [14:0] VEC [14] = '{
    {8'd0,  7'b1000010}, {8'd5,  7'b1000010}, {8'd6,  7'b0000000},
    {8'd7,  7'b0100000}, {8'd8,  7'b0100000}, {8'd9,  7'b0000000},
    {8'd12, 7'b1000110}, {8'd21, 7'b1000010}, {8'd24, 7'b1000011},
    {8'd33, 7'b1000011}, {8'd40, 7'b0010000}, {8'd47, 7'b0111000},
    {8'd48, 7'b0110000}, {8'd59, 7'b0000000}
  };

  task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expd);
    nchk++;
    if (actual !== expd) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expd);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic wait_pos(input int h, input int v);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (col_out == 14'(h) && row_out == 14'(v)) return;
    end
    nchk++; nerr++;
    $display("FAIL R1 position actual=%0d,%0d expected=%0d,%0d", col_out, row_out, h, v);
  endtask

  initial begin
    #(5.0 * 150000);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(5'd0, rv);  chk("R11 ctrl", rv, 32'h0);
    rd(5'd1, rv);  chk("R11 hsize", rv, 32'h0);
    rd(5'd14, rv); chk("R11 stamp", rv, 32'h0);
    rd(5'd15, rv); chk("R11 status", rv, 32'h0);
    chk("R11 outputs", {de_out, hsync_out, vsync_out, kick_pri_out, kick_sec_out, col_out, row_out}, 32'h0);

    // configuration, shadow off
    wr(5'd1,  32'h0009_0006);
    wr(5'd2,  32'h8002_0001);
    wr(5'd3,  32'h0005_0004);
    wr(5'd4,  32'h8001_0000);
    wr(5'd5,  32'h8004_0007);
    wr(5'd6,  32'h8001_0002);
    wr(5'd7,  32'h0001_0001);
    wr(5'd8,  32'h0003_0004);
    wr(5'd9,  32'd5);
    wr(5'd10, 32'd1);
    wr(5'd11, BG);
    rd(5'd2, rv); chk("R3 readback", rv, 32'h8002_0001);
    wr(5'd12, 32'd1);

    // vector walk: R1 R2 R3 R4 R5
    begin
      int cur;
      cur = 0;
      foreach (VEC[i]) begin
        while (cur < int'(VEC[i][14:7])) begin
          @(negedge clk);
          cur++;
        end
        chk("R1 col", {18'b0, col_out}, cur % HTOT);
        chk("R1 row", {18'b0, row_out}, cur / HTOT);
        chk("R2 R3 R4 R5 vector",
            {25'b0, de_out, hsync_out, vsync_out, kick_pri_out, kick_sec_out, src_out},
            {25'b0, VEC[i][6:0]});
      end
    end

    // R9 timestamp after one frame
    @(negedge clk);
    rd(5'd14, rv); chk("R9 stamp", rv, 32'h0000_4000);

    // R7 shadowed mode change
    wr(5'd0, 32'd1);
    wr(5'd9, 32'd1);
    chk("R7 old mode kept", {30'b0, src_out}, 32'd2);
    rd(5'd9, rv);  chk("R7 readback shadow", rv, 32'd1);
    wr(5'd13, 32'd1);
    rd(5'd13, rv); chk("R7 token pending", rv, 32'd1);
    chk("R7 old mode before wrap", {30'b0, src_out}, 32'd2);
    wait_pos(0, 0);
    chk("R7 new mode at frame start", {30'b0, src_out}, 32'd1);
    chk("R5 background color", {2'b0, color_out}, BG);
    rd(5'd13, rv); chk("R7 token cleared", rv, 32'd0);

    // direct write, then R6 panic
    wr(5'd0, 32'd0);
    wr(5'd9, 32'd5);
    wait_pos(4, 2);
    chk("R5 secondary on top", {30'b0, src_out}, 32'd3);
    chk("R5 color zero for plane", {2'b0, color_out}, 32'd0);
    panic_in = 1'b1;
    #1;
    chk("R6 panic mode", {30'b0, src_out}, 32'd1);
    panic_in = 1'b0;

    // R10 status flags
    wait_pos(1, 1);
    sec_empty_in = 1'b1;
    @(negedge clk);
    sec_empty_in = 1'b0;
    rd(5'd15, rv); chk("R10 empty ignored on primary", rv, 32'h0);
    wait_pos(4, 3);
    sec_empty_in = 1'b1;
    @(negedge clk);
    sec_empty_in = 1'b0;
    rd(5'd15, rv); chk("R10 empty flag set", rv, 32'h0001_0000);
    repeat (3) @(negedge clk);
    rd(5'd15, rv); chk("R10 empty flag sticky", rv, 32'h0001_0000);
    wr(5'd16, 32'h0001_0000);
    rd(5'd15, rv); chk("R10 clear", rv, 32'h0);
    sec_sync_in = 1'b1;
    wait_pos(0, 0);
    sec_sync_in = 1'b0;
    rd(5'd15, rv); chk("R10 sync flag", rv, 32'h0100_0000);
    wr(5'd16, 32'h0001_0000);
    rd(5'd15, rv); chk("R10 sync clear", rv, 32'h0);

    // R8 load while stopped
    wr(5'd12, 32'd0);
    @(negedge clk);
    chk("R1 stopped home", {18'b0, col_out, row_out} , 32'h0);
    chk("R1 stopped outputs", {29'b0, de_out, hsync_out, vsync_out}, 32'h0);
    wr(5'd0, 32'd1);
    wr(5'd1, 32'h0009_0003);
    wr(5'd13, 32'd1);
    rd(5'd13, rv); chk("R8 pending", rv, 32'd1);
    @(negedge clk);
    rd(5'd13, rv); chk("R8 load done", rv, 32'd0);
    wr(5'd12, 32'd1);
    repeat (2) @(negedge clk);
    chk("R8 de col 2", {31'b0, de_out}, 32'd1);
    @(negedge clk);
    chk("R8 narrower active", {31'b0, de_out}, 32'd0);

    // R4 strobe disabled
    wr(5'd0, 32'd0);
    wr(5'd5, 32'h0004_0007);
    wait_pos(7, 4);
    chk("R4 kick disabled", {31'b0, kick_pri_out}, 32'd0);
    chk("R3 hsync at disabled kick", {30'b0, hsync_out, vsync_out}, 32'd3);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

endmodule